// File: doc/BRIEF.md
# Binary/Decimal Add-Subtract Unit with Carry

This block performs add-with-carry and subtract-with-carry for an accumulator-style processor. It combines an accumulator value with a second operand, which may come from memory or from an immediate field. Subtraction sends the bitwise complement of the operand through the same adder. Carry-in is always added, so on a subtract a carry of 1 means that no borrow is pending.

In binary mode, subtracting V gives exactly the same result and flags as adding ~V. When decimal mode is requested, each 4-bit digit is corrected as packed BCD. Decimal mode is the only case where the two operations give different answers. The build parameter `DEC_EN` set to 0 removes decimal correction, and the decimal request input is then ignored.

Each operation is presented with a one-cycle `in_valid` strobe. The result and the four flags are registered. They appear one clock later together with a single-cycle `out_done` pulse, and they hold until the next strobe. The unit accepts a new operation on every cycle. There is no back-pressure: a strobe is never refused, and `out_done` cannot be stalled.

Top module: `asc_unit`

## Requirements
- R1: With decimal off and `in_sub`=0, {`out_c`,`out_res`} equals `in_acc` + `in_opd` + `in_carry` as a 9-bit sum.
- R2: With decimal off and `in_sub`=1, {`out_c`,`out_res`} equals `in_acc` + ~`in_opd` + `in_carry`. `out_c`=1 means no borrow, and `in_carry`=0 takes one extra unit off the result.
- R3: With decimal off, subtracting V gives the same result and the same C, Z, N and V flags as adding ~V with the same carry-in. For example, adding 0xFF matches subtracting 0x00.
- R4: `out_v` is the XOR of the carry into bit 7 and the carry out of bit 7 of the binary sum. It is formed the same way for add and subtract, and in both modes.
- R5: `out_z` is 1 exactly when `out_res` is 0x00, and `out_n` equals `out_res` bit 7. Both are taken from the final (decimal-corrected) result.
- R6: In a decimal add, a digit whose sum exceeds 9 has 6 added to it and passes a carry to the next digit. `out_c` is the carry from the top digit (0x58+0x46 gives 0x04 with C=1).
- R7: In a decimal subtract, a digit that produces no carry (a borrow) has 6 taken from it. `out_c` is the carry from the top digit (0x00−0x01 with carry-in 1 gives 0x99 with C=0).
- R8: With `DEC_EN`=0, `in_dec` has no effect and every operation is binary.
- R9: Results and flags update on the first rising edge after `in_valid`. `out_done` is high for exactly that one cycle, and all outputs hold while `in_valid` is low.
- R10: During reset and after it, `out_done`, `out_res` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| in_sub | input | 1 | 1 = subtract with carry, 0 = add with carry |
| in_acc | input | 8 | Accumulator operand |
| in_opd | input | 8 | Memory or immediate operand |
| in_carry | input | 1 | Carry-in (inverted borrow on subtract) |
| in_dec | input | 1 | Decimal correction request |
| out_done | output | 1 | One-cycle pulse when results are updated |
| out_res | output | 8 | Registered result |
| out_c | output | 1 | Carry flag |
| out_z | output | 1 | Zero flag |
| out_n | output | 1 | Negative flag |
| out_v | output | 1 | Overflow flag |

## Verification
Every result, flag and `out_done` is due on the first rising edge after the strobe. The bench drives inputs on falling edges and reads the outputs on the falling edge that follows that rising edge. In the full binary sweep a new operation enters every cycle. The outputs of the previous operation are therefore checked on the same falling edge, just before the next operation is driven. Decimal and corner vectors, the reset state and the hold behaviour are checked one operation at a time. Each of these checks is sampled one falling edge after its strobe, and a further edge is used for the hold checks.

// File: rtl/asc_pkg.sv
package asc_pkg;
  typedef enum logic {
    ASC_ADD = 1'b0,
    ASC_SUB = 1'b1
  } asc_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } asc_flags_t;
endpackage

// File: rtl/asc_digit.sv
module asc_digit #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          dec,
  input  logic          sub,
  output logic [DW-1:0] d,
  output logic          cout
);
  localparam logic [DW:0]   LIMIT = (DW+1)'(9);
  localparam logic [DW-1:0] ADJ   = DW'(6);

  logic [DW:0] raw;
  assign raw = {1'b0, a} + {1'b0, b} + (DW+1)'(cin);

  always_comb begin
    if (!dec) begin
      cout = raw[DW];
      d    = raw[DW-1:0];
    end else if (!sub) begin
      if (raw > LIMIT) begin
        cout = 1'b1;
        d    = raw[DW-1:0] + ADJ;
      end else begin
        cout = 1'b0;
        d    = raw[DW-1:0];
      end
    end else begin
      cout = raw[DW];
      d    = raw[DW] ? raw[DW-1:0] : raw[DW-1:0] - ADJ;
    end
  end
endmodule

// File: rtl/asc_core.sv
module asc_core
  import asc_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit DEC_EN = 1'b1
) (
  input  asc_op_e          op,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] opd,
  input  logic             cin,
  input  logic             dec,
  output logic [WIDTH-1:0] res,
  output asc_flags_t       flags
);
  localparam int DIGITS = WIDTH / 4;

  logic             is_sub;
  logic             dec_eff;
  logic [WIDTH-1:0] opd_eff;
  logic [DIGITS:0]  chain;

  assign is_sub  = (op == ASC_SUB);
  assign opd_eff = is_sub ? ~opd : opd;

  generate
    if (DEC_EN) begin : g_dec
      assign dec_eff = dec;
    end else begin : g_bin
      logic unused_dec;
      assign unused_dec = dec;
      assign dec_eff    = 1'b0;
    end
  endgenerate

  assign chain[0] = cin;
  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      asc_digit #(.DW(4)) i_digit (
        .a    (acc[4*g +: 4]),
        .b    (opd_eff[4*g +: 4]),
        .cin  (chain[g]),
        .dec  (dec_eff),
        .sub  (is_sub),
        .d    (res[4*g +: 4]),
        .cout (chain[g+1])
      );
    end
  endgenerate

  // Binary carry into and out of the sign bit, used for overflow in all modes
  logic [WIDTH-1:0] low_sum;
  logic [1:0]       top_sum;
  assign low_sum = {1'b0, acc[WIDTH-2:0]} + {1'b0, opd_eff[WIDTH-2:0]} + WIDTH'(cin);
  assign top_sum = 2'(acc[WIDTH-1]) + 2'(opd_eff[WIDTH-1]) + 2'(low_sum[WIDTH-1]);

  assign flags.c = chain[DIGITS];
  assign flags.z = (res == '0);
  assign flags.n = res[WIDTH-1];
  assign flags.v = low_sum[WIDTH-1] ^ top_sum[1];
endmodule

// File: rtl/asc_unit.sv
module asc_unit
  import asc_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit DEC_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sub,
  input  logic [WIDTH-1:0] in_acc,
  input  logic [WIDTH-1:0] in_opd,
  input  logic             in_carry,
  input  logic             in_dec,
  output logic             out_done,
  output logic [WIDTH-1:0] out_res,
  output logic             out_c,
  output logic             out_z,
  output logic             out_n,
  output logic             out_v
);
  logic [WIDTH-1:0] nxt_res;
  asc_flags_t       nxt_flags;
  asc_flags_t       flg_q;

  asc_core #(.WIDTH(WIDTH), .DEC_EN(DEC_EN)) i_core (
    .op    (asc_op_e'(in_sub)),
    .acc   (in_acc),
    .opd   (in_opd),
    .cin   (in_carry),
    .dec   (in_dec),
    .res   (nxt_res),
    .flags (nxt_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done <= 1'b0;
      out_res  <= '0;
      flg_q    <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_res <= nxt_res;
        flg_q   <= nxt_flags;
      end
    end
  end

  assign out_c = flg_q.c;
  assign out_z = flg_q.z;
  assign out_n = flg_q.n;
  assign out_v = flg_q.v;
endmodule

// File: rtl/asc_unit_chk.sv
module asc_unit_chk #(
  parameter int WIDTH  = 8,
  parameter bit DEC_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sub,
  input logic [WIDTH-1:0] in_acc,
  input logic [WIDTH-1:0] in_opd,
  input logic             in_carry,
  input logic             in_dec,
  input logic             out_done,
  input logic [WIDTH-1:0] out_res,
  input logic             out_c,
  input logic             out_z,
  input logic             out_n,
  input logic             out_v
);
  logic [WIDTH-1:0] opd_w;
  logic [WIDTH:0]   sum_w;
  logic             ovf_w;
  logic             bin_w;

  assign opd_w = in_sub ? ~in_opd : in_opd;
  assign sum_w = {1'b0, in_acc} + {1'b0, opd_w} + (WIDTH+1)'(in_carry);
  assign ovf_w = (in_acc[WIDTH-1] == opd_w[WIDTH-1]) && (sum_w[WIDTH-1] != in_acc[WIDTH-1]);
  assign bin_w = !(DEC_EN && in_dec);

  AST_BINARY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bin_w) |=> ({out_c, out_res} == $past(sum_w))); // R1

  AST_SUB_AS_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bin_w && in_sub) |=> ({out_c, out_res} == $past(sum_w))); // R2

  AST_NO_DEC_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !DEC_EN) |=> (out_res == $past(sum_w[WIDTH-1:0]))); // R8

  AST_OVERFLOW_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_v == $past(ovf_w))); // R4

  AST_ZERO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> ((out_z == (out_res == '0)) && (out_n == out_res[WIDTH-1]))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_done && $stable(out_res) && $stable(out_c) && $stable(out_v))); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (out_done == 1'b0 && out_res == '0); // R10
    end
  end
endmodule

bind asc_unit asc_unit_chk #(.WIDTH(WIDTH), .DEC_EN(DEC_EN)) i_chk (.*);

// File: tb/test_asc_unit.sv
module test_asc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       in_valid = 1'b0, in_sub = 1'b0, in_carry = 1'b0, in_dec = 1'b0;
  logic [7:0] in_acc = '0, in_opd = '0;
  logic       out_done, out_c, out_z, out_n, out_v;
  logic [7:0] out_res;

  logic       n_valid = 1'b0, n_sub = 1'b0, n_carry = 1'b0, n_dec = 1'b0;
  logic [7:0] n_acc = '0, n_opd = '0;
  logic       n_done, n_c, n_z, n_n, n_v;
  logic [7:0] n_res;

  asc_unit #(.WIDTH(8), .DEC_EN(1'b1)) i_asc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
    .in_acc(in_acc), .in_opd(in_opd), .in_carry(in_carry), .in_dec(in_dec),
    .out_done(out_done), .out_res(out_res), .out_c(out_c), .out_z(out_z),
    .out_n(out_n), .out_v(out_v));

  asc_unit #(.WIDTH(8), .DEC_EN(1'b0)) i_asc_unit_nodec (
    .clk(clk), .rst_n(rst_n), .in_valid(n_valid), .in_sub(n_sub),
    .in_acc(n_acc), .in_opd(n_opd), .in_carry(n_carry), .in_dec(n_dec),
    .out_done(n_done), .out_res(n_res), .out_c(n_c), .out_z(n_z),
    .out_n(n_n), .out_v(n_v));

  int checks = 0;
  int fails  = 0;

  // Entry: pad, sub, dec, acc, opd, carry-in, expected result, expected {c,z,n,v}
  localparam logic [31:0] VECS [10] = '{
    {1'b0, 1'b0, 1'b1, 8'h58, 8'h46, 1'b0, 8'h04, 4'b1001},
    {1'b0, 1'b0, 1'b1, 8'h09, 8'h01, 1'b0, 8'h10, 4'b0000},
    {1'b0, 1'b0, 1'b1, 8'h99, 8'h00, 1'b1, 8'h00, 4'b1100},
    {1'b0, 1'b0, 1'b1, 8'h79, 8'h00, 1'b1, 8'h80, 4'b0010},
    {1'b0, 1'b1, 1'b1, 8'h46, 8'h12, 1'b1, 8'h34, 4'b1000},
    {1'b0, 1'b1, 1'b1, 8'h12, 8'h21, 1'b1, 8'h91, 4'b0010},
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h01, 1'b1, 8'h99, 4'b0010},
    {1'b0, 1'b1, 1'b1, 8'h50, 8'h25, 1'b0, 8'h24, 4'b1000},
    {1'b0, 1'b0, 1'b0, 8'h7F, 8'h01, 1'b0, 8'h80, 4'b0011},
    {1'b0, 1'b1, 1'b0, 8'h80, 8'h01, 1'b1, 8'h7F, 4'b1001}
  };

  function automatic logic [11:0] bin_model(input logic sub, input logic [7:0] a,
                                            input logic [7:0] b, input logic ci);
    logic [7:0] be;
    logic [8:0] s;
    logic       v;
    be = sub ? ~b : b;
    s  = {1'b0, a} + {1'b0, be} + {8'b0, ci};
    v  = (a[7] == be[7]) && (s[7] != a[7]);
    return {s[7:0], s[8], (s[7:0] == 8'h00), s[7], v};
  endfunction

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual res=%h cznv=%b expected res=%h cznv=%b",
               tag, got[11:4], got[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [11:0] exp_prev;
    logic [11:0] got_prev;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 in reset", {out_res, out_c, out_z, out_n, out_v, out_done, 3'b0}, 12'h000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 after reset", {out_res, out_c, out_z, out_n, out_v, out_done, 3'b0}, 12'h000);

    // Table walk: decimal R6 R7 and binary corner vectors
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sub   = VECS[k][30];
      in_dec   = VECS[k][29];
      in_acc   = VECS[k][28:21];
      in_opd   = VECS[k][20:13];
      in_carry = VECS[k][12];
      @(negedge clk);
      in_valid = 1'b0;
      chk(VECS[k][29] ? (VECS[k][30] ? "R7 R5 R4 decimal sub" : "R6 R5 R4 decimal add")
                      : "R1 R2 R4 binary corner",
          {out_res, out_c, out_z, out_n, out_v}, VECS[k][11:0]);
    end

    // R9: done lasts one cycle and outputs hold while idle
    @(negedge clk);
    in_valid = 1'b1; in_sub = 1'b0; in_dec = 1'b0;
    in_acc = 8'h3C; in_opd = 8'hC4; in_carry = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; in_acc = 8'h01; in_opd = 8'h01;
    chk("R9 done with result", {out_res, out_c, out_z, out_n, out_done, 3'b0},
        {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 3'b0});
    @(negedge clk);
    chk("R9 done drops, result held", {out_res, out_c, out_z, out_n, out_done, 3'b0},
        {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'b0});

    // R8: decimal request ignored when decimal support is removed
    @(negedge clk);
    n_valid = 1'b1; n_sub = 1'b0; n_dec = 1'b1;
    n_acc = 8'h58; n_opd = 8'h46; n_carry = 1'b0;
    @(negedge clk);
    n_sub = 1'b1; n_acc = 8'h12; n_opd = 8'h21; n_carry = 1'b1;
    chk("R8 add with decimal request", {n_res, n_c, n_z, n_n, n_v}, bin_model(1'b0, 8'h58, 8'h46, 1'b0));
    @(negedge clk);
    n_valid = 1'b0; n_dec = 1'b0;
    chk("R8 sub with decimal request", {n_res, n_c, n_z, n_n, n_v}, bin_model(1'b1, 8'h12, 8'h21, 1'b1));

    // Full binary sweep: add on main instance, subtract of complement on the other
    exp_prev = '0;
    for (int i = 0; i <= 131072; i++) begin
      @(negedge clk);
      if (i > 0) begin
        got_prev = {out_res, out_c, out_z, out_n, out_v};
        chk("R1 R4 R5 sweep add", got_prev, exp_prev);
        chk("R2 sweep sub", {n_res, n_c, n_z, n_n, n_v},
            bin_model(1'b1, in_acc, ~in_opd, in_carry));
        chk("R3 sub of complement equals add", {n_res, n_c, n_z, n_n, n_v}, got_prev);
      end
      if (i < 131072) begin
        in_valid = 1'b1; in_sub = 1'b0; in_dec = 1'b0;
        in_acc = i[16:9]; in_opd = i[8:1]; in_carry = i[0];
        n_valid = 1'b1; n_sub = 1'b1; n_dec = 1'b0;
        n_acc = i[16:9]; n_opd = ~i[8:1]; n_carry = i[0];
        exp_prev = bin_model(1'b0, i[16:9], i[8:1], i[0]);
      end else begin
        in_valid = 1'b0;
        n_valid  = 1'b0;
      end
    end

    report();
  end
endmodule